// File: doc/BRIEF.md
# Modem Control and Status with Internal Loopback

This block holds the modem control byte and the modem status byte of a 16550-style serial port. It also holds the internal loopback path that turns modem outputs back into modem inputs. A host writes the control byte and reads the status byte over a small bus with a 3-bit address and 8-bit data. The upper nibble of the status byte shows the present level of the four modem inputs. The lower nibble holds sticky change flags.

When loopback is off, the four external modem inputs pass through a synchroniser before change detection, and the four control outputs drive the pins. When loopback is on, the pins are held deasserted and each control bit drives one status input. Any change flag that is set raises a modem-status interrupt request while the enable input is high. Reading the status byte clears the flags. The request is only a pending flag: it is left to the port's interrupt priority logic.

Top module: `mdm_loop_status`

## Requirements
- R1: After reset, the control byte reads 0x00, the status byte reads 0x00 while all external inputs are low, and the interrupt request is low.
- R2: A write at address 4 stores data bits 5:0 into the control byte (bit0 DTR, bit1 RTS, bit2 AUX1, bit3 AUX2, bit4 loop enable, bit5 flow enable). Bits 7:6 read back as 0. Writes at other addresses leave the control byte unchanged. A read at an address other than 4 or 6 returns 0x00.
- R3: With loop enable clear, `out_dtr`, `out_rts`, `out_aux1` and `out_aux2` follow control bits 0 to 3. With loop enable set, all four are held at 0.
- R4: With loop enable set, status bit4 (CTS) follows RTS, bit5 (DSR) follows DTR, bit6 (RI) follows AUX1, and bit7 (DCD) follows AUX2. Each takes effect one clock after the control write.
- R5: With loop enable clear, status bits 4/5/6/7 show `ext_cts`/`ext_dsr`/`ext_ri`/`ext_dcd` after a two-stage synchroniser, three clocks after a pin change.
- R6: Status bit0 sets on any change of CTS, bit1 on any change of DSR and bit3 on any change of DCD, in either direction. Several flags can set in the same clock.
- R7: Status bit2 sets only when RI goes from 1 to 0. It never sets when RI goes from 0 to 1.
- R8: A read at address 6 returns the status byte and then clears bits 3:0. A change detected in the same clock as the read still sets its flag.
- R9: `irq_modem` is high exactly when `msi_en` is high and any of status bits 3:0 is set. It drops after a status read that clears the flags.
- R10: Setting or clearing loop enable sets change flags for every status input whose selected source differs between the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data for the current address |
| stat_byte | output | 8 | Live status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| irq_modem | output | 1 | Modem-status interrupt request |
| ext_cts | input | 1 | External clear-to-send |
| ext_dsr | input | 1 | External data-set-ready |
| ext_ri | input | 1 | External ring indicate |
| ext_dcd | input | 1 | External carrier detect |
| out_dtr | output | 1 | Data-terminal-ready pin |
| out_rts | output | 1 | Request-to-send pin |
| out_aux1 | output | 1 | Auxiliary output 1 pin |
| out_aux2 | output | 1 | Auxiliary output 2 pin |

## Verification
The hardest case to reach from the ports is a line change that lands in the same clock as a status read, where the new flag must survive the clear. The bench times an external pin edge so that its third synchroniser clock falls on the read strobe. It then reads again to find the flag. It also sweeps all 256 old-to-new nibble transitions, once through loopback and once through the external pins. This covers every combination of rising and falling edges, including RI rises that must not set a flag.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // control byte field positions (read back by software, order is behaviour)
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_AUX1 = 2;
   localparam int CB_AUX2 = 3;
   localparam int CB_LOOP = 4;
   localparam int CB_FLOW = 5;
   localparam int CB_USED = 6;

   // modem input lines, packed in status-byte order (bit7..bit4)
   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_line_t;

   localparam int LINE_W = $bits(mdm_line_t);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES > 4) begin : g_bad_stages
      $error("mdm_sync: STAGES above 4 is not supported");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int MY_ADDR = 4,
   parameter int USED_BITS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   output logic [DATA_W-1:0] ctrl_q
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'((1 << USED_BITS) - 1);

   if (USED_BITS > DATA_W) begin : g_bad_used
      $error("mdm_ctrl_reg: USED_BITS exceeds DATA_W");
   end

   logic wr_hit;
   assign wr_hit = wr && (addr == ADDR_W'(MY_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (wr_hit) ctrl_q <= wdata & KEEP;
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
   import mdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mdm_line_t lines,
   input  logic      clr,
   output mdm_line_t cur,
   output logic [3:0] delta
);
   logic [3:0] chg;

   // bit0 CTS, bit1 DSR, bit2 RI trailing edge, bit3 DCD
   always_comb begin
      chg[0] = lines.cts ^ cur.cts;
      chg[1] = lines.dsr ^ cur.dsr;
      chg[2] = cur.ri & ~lines.ri;
      chg[3] = lines.dcd ^ cur.dcd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur   <= '0;
         delta <= '0;
      end else begin
         cur   <= lines;
         delta <= clr ? chg : (delta | chg);
      end
   end

   AST_RI_RISE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cur.ri) && !$past(delta[2])) |-> !delta[2]); // R7
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((delta & $past(delta)) == $past(delta))); // R8
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr) && $stable(cur)) |-> (delta == 4'h0)); // R8
endmodule

// File: rtl/mdm_loop_status.sv
module mdm_loop_status
   import mdm_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int CTRL_ADDR   = 4,
   parameter int STAT_ADDR   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] stat_byte,
   input  logic              msi_en,
   output logic              irq_modem,
   input  logic              ext_cts,
   input  logic              ext_dsr,
   input  logic              ext_ri,
   input  logic              ext_dcd,
   output logic              out_dtr,
   output logic              out_rts,
   output logic              out_aux1,
   output logic              out_aux2
);
   if (DATA_W != 2 * LINE_W) begin : g_bad_width
      $error("mdm_loop_status: DATA_W must hold lines plus flags");
   end
   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("mdm_loop_status: control and status addresses collide");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic              loop_on;
   mdm_line_t         ext_raw, ext_sync, loop_src, sel, cur;
   logic [3:0]        delta;
   logic              rd_stat;

   mdm_ctrl_reg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MY_ADDR(CTRL_ADDR), .USED_BITS(CB_USED)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
      .wr(bus_wr), .ctrl_q(ctrl_q)
   );

   assign loop_on = ctrl_q[CB_LOOP];

   assign ext_raw = '{dcd: ext_dcd, ri: ext_ri, dsr: ext_dsr, cts: ext_cts};

   mdm_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_raw), .q(ext_sync)
   );

   // loopback wiring: DTR->DSR, RTS->CTS, AUX1->RI, AUX2->DCD
   assign loop_src = '{dcd: ctrl_q[CB_AUX2], ri: ctrl_q[CB_AUX1],
                       dsr: ctrl_q[CB_DTR],  cts: ctrl_q[CB_RTS]};
   assign sel = loop_on ? loop_src : ext_sync;

   assign rd_stat = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));

   mdm_delta u_delta (
      .clk(clk), .rst_n(rst_n), .lines(sel), .clr(rd_stat),
      .cur(cur), .delta(delta)
   );

   assign stat_byte = {cur, delta};
   assign irq_modem = msi_en && (delta != 4'h0);

   assign out_dtr  = ctrl_q[CB_DTR]  & ~loop_on;
   assign out_rts  = ctrl_q[CB_RTS]  & ~loop_on;
   assign out_aux1 = ctrl_q[CB_AUX1] & ~loop_on;
   assign out_aux2 = ctrl_q[CB_AUX2] & ~loop_on;

   always_comb begin
      if (bus_addr == ADDR_W'(CTRL_ADDR))      bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata = stat_byte;
      else                                     bus_rdata = '0;
   end

   AST_LOOP_DSR_FROM_DTR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[CB_LOOP]) |-> (stat_byte[5] == $past(ctrl_q[CB_DTR]))); // R4
   AST_LOOP_RI_FROM_AUX1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[CB_LOOP]) |-> (stat_byte[6] == $past(ctrl_q[CB_AUX1]))); // R4
   AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_modem) |-> ($past(rd_stat) || !msi_en)); // R9
endmodule

// File: tb/mdm_loop_status_tb.sv
`timescale 1ns/1ps
module mdm_loop_status_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata, stat_byte;
   logic       msi_en = 1'b0, irq_modem;
   logic       ext_cts = 0, ext_dsr = 0, ext_ri = 0, ext_dcd = 0;
   logic       out_dtr, out_rts, out_aux1, out_aux2;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mdm_loop_status u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .stat_byte(stat_byte), .msi_en(msi_en), .irq_modem(irq_modem),
      .ext_cts(ext_cts), .ext_dsr(ext_dsr), .ext_ri(ext_ri), .ext_dcd(ext_dcd),
      .out_dtr(out_dtr), .out_rts(out_rts), .out_aux1(out_aux1), .out_aux2(out_aux2)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_ext(input logic [3:0] e); // {dcd,ri,dsr,cts}
      @(negedge clk);
      {ext_dcd, ext_ri, ext_dsr, ext_cts} = e;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [3:0] flags(input logic [3:0] p, input logic [3:0] v);
      // nibble order {dcd,ri,dsr,cts}
      return {p[3] ^ v[3], p[2] & ~v[2], p[1] ^ v[1], p[0] ^ v[0]};
   endfunction

   function automatic logic [3:0] loop_lines(input logic [3:0] c);
      // c = {aux2,aux1,rts,dtr} -> {dcd,ri,dsr,cts}
      return {c[3], c[2], c[0], c[1]};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd4, d); check("R1 ctrl", d, 8'h00);
      rd(3'd6, d); check("R1 status", d, 8'h00);
      check("R1 irq", {7'b0, irq_modem}, 8'h00);

      // R2 write/readback and address decode
      wr(3'd4, 8'hFF); rd(3'd4, d); check("R2 upper bits", d, 8'h3F);
      wr(3'd4, 8'h00); wr(3'd5, 8'h2A); rd(3'd4, d); check("R2 other addr write", d, 8'h00);
      rd(3'd3, d); check("R2 unmapped read", d, 8'h00);

      // R3 pins follow control outside loop, quiet in loop
      wr(3'd4, 8'h0B);
      check("R3 pins no loop", {4'b0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h0B);
      wr(3'd4, 8'h1F);
      check("R3 pins loop", {4'b0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h00);
      wr(3'd4, 8'h00);
      repeat (2) @(negedge clk);
      rd(3'd6, d);

      // R4 R6 R7 R9 loopback sweep of all transitions
      msi_en = 1'b1;
      for (int p = 0; p < 16; p++) begin
         for (int v = 0; v < 16; v++) begin
            logic [3:0] pl, vl, f;
            pl = loop_lines(4'(p)); vl = loop_lines(4'(v));
            f  = flags(pl, vl);
            wr(3'd4, 8'h10 | 8'(p));
            @(negedge clk);
            rd(3'd6, d);
            wr(3'd4, 8'h10 | 8'(v));
            @(negedge clk);
            check("R9 irq loop", {7'b0, irq_modem}, {7'b0, |f});
            rd(3'd6, d);
            check("R4 R6 R7 loop status", d, {vl, f});
         end
      end
      rd(3'd6, d);
      check("R8 cleared after read", d, {loop_lines(4'hF), 4'h0});
      check("R9 irq drops", {7'b0, irq_modem}, 8'h00);

      // R10 mode switch creates flags
      wr(3'd4, 8'h01); @(negedge clk); rd(3'd6, d);
      wr(3'd4, 8'h11); @(negedge clk); rd(3'd6, d);
      check("R10 enter loop", d, 8'h22);
      wr(3'd4, 8'h01); @(negedge clk); rd(3'd6, d);
      check("R10 leave loop", d, 8'h02);
      wr(3'd4, 8'h00);

      // R5 R6 R7 external sweep through synchroniser
      for (int p = 0; p < 16; p++) begin
         for (int v = 0; v < 16; v++) begin
            set_ext(4'(p));
            rd(3'd6, d);
            set_ext(4'(v));
            rd(3'd6, d);
            check("R5 R6 R7 ext status", d, {4'(v), flags(4'(p), 4'(v))});
         end
      end
      set_ext(4'h0); rd(3'd6, d); rd(3'd6, d);

      // R5 synchroniser latency: not visible after two clocks
      @(negedge clk); ext_dsr = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R5 two clocks", stat_byte, 8'h00);
      @(negedge clk);
      check("R5 three clocks", stat_byte, 8'h22);
      rd(3'd6, d);

      // R8 change coinciding with a status read survives the clear
      @(negedge clk); ext_cts = 1'b1;
      @(negedge clk); @(negedge clk);
      bus_addr = 3'd6; bus_rd = 1'b1;
      #1 check("R8 coincident read data", bus_rdata, 8'h20);
      @(negedge clk); bus_rd = 1'b0;
      rd(3'd6, d);
      check("R8 flag survives", d, 8'h31);

      // R9 enable gates request
      msi_en = 1'b0;
      @(negedge clk); ext_dcd = 1'b1;
      repeat (4) @(negedge clk);
      check("R9 disabled", {7'b0, irq_modem}, 8'h00);
      msi_en = 1'b1; #1;
      check("R9 enabled", {7'b0, irq_modem}, 8'h01);
      rd(3'd6, d);
      check("R9 after read", {7'b0, irq_modem}, 8'h00);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule